// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block produces the row scan timing for a dot-matrix LCD whose column drive sits in separate segment driver chips. It walks through the common (row) outputs one at a time and keeps exactly one common active. The number of rows in a frame is selectable between a full count and a half count. The frame rate is selectable between a base rate and twice that rate. The pace comes from a single-cycle enable derived from a slow time base. A programmable divider turns that enable into line periods.

Alongside the common vector the block drives three handshake signals for the segment drivers. A frame marker is high for the whole first line. A line clock pulses once per line advance. A polarity signal flips once per frame. All three come from the same registers as the row counter, so they cannot drift out of phase with the scan.

Top module: `lcd_com_scan`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters row 0 with `com_en` equal to 1 (only bit 0 set), `frame_o` high, `m_o` low and `cl_o` low.
- R2: A line lasts exactly L ticks of `tick_en`, where L = TICK_HZ / (rate × rows). The rate is RATE_LO when `rate_hi`=0 and 2×RATE_LO when `rate_hi`=1. The row count is NUM_COM when `duty_full`=1 and NUM_COM/2 when `duty_full`=0.
- R3: At each line end `row_idx` goes up by one. From the last row (NUM_COM−1 in full duty, NUM_COM/2−1 in half duty) it goes to 0 instead.
- R4: `com_en` has only bit `row_idx` set when that row lies inside the active row count. When `duty_full`=0, bits NUM_COM/2 and above are always 0.
- R5: `cl_o` is high for the one clock cycle that follows the edge where `row_idx` advanced, and low in every other cycle.
- R6: `frame_o` is high exactly while `row_idx` is 0.
- R7: `m_o` inverts each time the row wraps to 0 and at no other time.
- R8: In a cycle where `tick_en` is low, the row, the line count and `m_o` keep their values and `cl_o` is low in the next cycle.
- R9: Changing the mode mid-line takes effect at once. If the row lies beyond the new last row, the next line end wraps it to 0. If the tick count already reaches the new line length, the line ends on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle enable from the slow time base |
| duty_full | input | 1 | 1: NUM_COM rows, 0: NUM_COM/2 rows |
| rate_hi | input | 1 | 1: 2×RATE_LO frame rate, 0: RATE_LO |
| com_en | output | NUM_COM | One-hot common enables |
| row_idx | output | $clog2(NUM_COM) | Row being scanned |
| frame_o | output | 1 | First-line marker |
| cl_o | output | 1 | Line advance pulse |
| m_o | output | 1 | Alternating drive polarity |

## Verification
The bench builds the block with TICK_HZ=4096, NUM_COM=32 and RATE_LO=64. With these values the four modes give line lengths of 1, 2, 2 and 4 ticks, so a full frame passes in tens of cycles. Every wrap, polarity flip and mode switch therefore comes many times within a short run. The one-tick line length stresses the case where the divider ends a line on every enable. Irregular tick patterns and mid-frame switches of duty and rate exercise the late-wrap and shortened-line paths.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic {
        DUTY_HALF = 1'b0,
        DUTY_FULL = 1'b1
    } duty_e;

    function automatic int unsigned line_len(int unsigned tick_hz, int unsigned rate,
                                             int unsigned rows);
        return tick_hz / (rate * rows);
    endfunction
endpackage

// File: rtl/lcd_line_div.sv
module lcd_line_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [DIV_W-1:0] limit,
    output logic             line_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic at_last;

    always_comb begin
        st_d     = st_q;
        at_last  = (st_q.cnt >= (limit - DIV_W'(1)));
        line_end = tick_en && at_last;
        if (tick_en) begin
            if (at_last) st_d.cnt = '0;
            else         st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic [ROW_W-1:0] last_row,
    output logic [ROW_W-1:0] row,
    output logic             frame,
    output logic             cl,
    output logic             m
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             frame;
        logic             cl;
        logic             m;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.cl = 1'b0;
        if (line_end) begin
            st_d.cl = 1'b1;
            if (st_q.row >= last_row) begin
                st_d.row = '0;
                st_d.m   = ~st_q.m;
            end else begin
                st_d.row = st_q.row + ROW_W'(1);
            end
        end
        st_d.frame = (st_d.row == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.row   <= '0;
            st_q.frame <= 1'b1;
            st_q.cl    <= 1'b0;
            st_q.m     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row   = st_q.row;
    assign frame = st_q.frame;
    assign cl    = st_q.cl;
    assign m     = st_q.m;
endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode #(
    parameter int NUM_COM = 32,
    parameter int ROW_W   = 5
) (
    input  logic [ROW_W-1:0]   row,
    input  logic               duty_full,
    output logic [NUM_COM-1:0] com_en
);
    localparam int HALF = NUM_COM / 2;

    for (genvar i = 0; i < NUM_COM; i++) begin : g_com
        if (i < HALF) begin : g_low
            assign com_en[i] = (row == ROW_W'(i));
        end else begin : g_high
            assign com_en[i] = duty_full && (row == ROW_W'(i));
        end
    end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
    parameter int TICK_HZ = 32768,
    parameter int NUM_COM = 32,
    parameter int RATE_LO = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick_en,
    input  logic                       duty_full,
    input  logic                       rate_hi,
    output logic [NUM_COM-1:0]         com_en,
    output logic [$clog2(NUM_COM)-1:0] row_idx,
    output logic                       frame_o,
    output logic                       cl_o,
    output logic                       m_o
);
    import lcd_scan_pkg::*;

    localparam int ROW_W   = $clog2(NUM_COM);
    localparam int HALF    = NUM_COM / 2;
    localparam int LT_F_LO = line_len(TICK_HZ, RATE_LO, NUM_COM);
    localparam int LT_F_HI = line_len(TICK_HZ, 2 * RATE_LO, NUM_COM);
    localparam int LT_H_LO = line_len(TICK_HZ, RATE_LO, HALF);
    localparam int LT_H_HI = line_len(TICK_HZ, 2 * RATE_LO, HALF);
    localparam int DIV_W   = $clog2(LT_H_LO + 1);

    duty_e            duty;
    logic [DIV_W-1:0] limit;
    logic [ROW_W-1:0] last_row;
    logic             line_end;

    always_comb begin
        duty = duty_e'(duty_full);
        if (duty == DUTY_FULL) begin
            last_row = ROW_W'(NUM_COM - 1);
            limit    = rate_hi ? DIV_W'(LT_F_HI) : DIV_W'(LT_F_LO);
        end else begin
            last_row = ROW_W'(HALF - 1);
            limit    = rate_hi ? DIV_W'(LT_H_HI) : DIV_W'(LT_H_LO);
        end
    end

    lcd_line_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .limit   (limit),
        .line_end(line_end)
    );

    lcd_row_seq #(.ROW_W(ROW_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .line_end(line_end),
        .last_row(last_row),
        .row     (row_idx),
        .frame   (frame_o),
        .cl      (cl_o),
        .m       (m_o)
    );

    lcd_com_decode #(.NUM_COM(NUM_COM), .ROW_W(ROW_W)) u_dec (
        .row      (row_idx),
        .duty_full(duty_full),
        .com_en   (com_en)
    );
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
    parameter int NUM_COM = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick_en,
    input logic                       duty_full,
    input logic [NUM_COM-1:0]         com_en,
    input logic [$clog2(NUM_COM)-1:0] row_idx,
    input logic                       frame_o,
    input logic                       cl_o,
    input logic                       m_o
);
    localparam int ROW_W = $clog2(NUM_COM);
    localparam int HALF  = NUM_COM / 2;

    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_en)); // R4
    AST_HALF_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
        !duty_full |-> (com_en[NUM_COM-1:HALF] == '0)); // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        cl_o |-> (row_idx == '0 || row_idx == ROW_W'($past(row_idx) + 1'b1))); // R3
    AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (rst)
        frame_o == (row_idx == '0)); // R6
    AST_M_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (m_o != $past(m_o)) |-> (cl_o && row_idx == '0)); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(row_idx) && $stable(m_o) && !cl_o)); // R8
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.NUM_COM(NUM_COM)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .duty_full(duty_full),
    .com_en   (com_en),
    .row_idx  (row_idx),
    .frame_o  (frame_o),
    .cl_o     (cl_o),
    .m_o      (m_o)
);

// File: tb/lcd_com_scan_tb.sv
module lcd_com_scan_tb;
    localparam int TICK_HZ = 4096;
    localparam int NCOM    = 32;
    localparam int RLO     = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick_en = 1'b0;
    logic            duty_full = 1'b1;
    logic            rate_hi = 1'b0;
    logic [NCOM-1:0] com_en;
    logic [4:0]      row_idx;
    logic            frame_o, cl_o, m_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string tag = "R2,R3";
    bit started = 0;

    int e_cnt = 0, e_row = 0;
    bit e_m = 0, e_cl = 0;

    always #10 clk = ~clk;

    lcd_com_scan #(.TICK_HZ(TICK_HZ), .NUM_COM(NCOM), .RATE_LO(RLO)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .duty_full(duty_full),
        .rate_hi(rate_hi), .com_en(com_en), .row_idx(row_idx),
        .frame_o(frame_o), .cl_o(cl_o), .m_o(m_o)
    );

    function automatic int rows_of(bit d);
        return d ? NCOM : NCOM / 2;
    endfunction

    function automatic int line_of(bit d, bit h);
        return TICK_HZ / ((h ? 2 * RLO : RLO) * rows_of(d));
    endfunction

    // reference model
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            e_cnt = 0; e_row = 0; e_m = 0; e_cl = 0;
        end else begin
            e_cl = 0;
            if (tick_en) begin
                if (e_cnt + 1 >= line_of(duty_full, rate_hi)) begin
                    e_cnt = 0;
                    e_cl  = 1;
                    if (e_row + 1 >= rows_of(duty_full)) begin
                        e_row = 0;
                        e_m   = ~e_m;
                    end else begin
                        e_row = e_row + 1;
                    end
                end else begin
                    e_cnt = e_cnt + 1;
                end
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [NCOM-1:0] e_com;
            string t;
            e_com = '0;
            if (e_row < rows_of(duty_full)) e_com[e_row] = 1'b1;
            t = rst ? "R1" : tag;
            chk(t, "row_idx", row_idx, e_row);
            chk(rst ? "R1" : "R4", "com_en", com_en, e_com);
            chk(rst ? "R1" : "R6", "frame_o", frame_o, (e_row == 0));
            chk(rst ? "R1" : "R5", "cl_o", cl_o, e_cl);
            chk(rst ? "R1" : "R7", "m_o", m_o, e_m);
        end
    end

    task automatic run(int n, int period);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = (period > 0) && ((i % period) == 0);
        end
    endtask

    task automatic run_rand(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = ($urandom % 3) != 0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2,R3: full duty, base rate, tick every cycle (line = 2 ticks)
        run(150, 1);
        // full duty, high rate (line = 1 tick), sparse ticks
        rate_hi = 1'b1;
        run(200, 3);
        // R8: tick held low
        tag = "R8";
        run(30, 0);
        tag = "R2,R3";
        // half duty, base rate (line = 4 ticks)
        duty_full = 1'b0; rate_hi = 1'b0;
        run_rand(400);
        rate_hi = 1'b1;
        run(200, 1);
        // R9: switch to half duty while row is beyond the half range
        tag = "R9";
        duty_full = 1'b1; rate_hi = 1'b0;
        @(negedge clk);
        tick_en = 1'b1;
        while (row_idx < 5'd20) @(negedge clk);
        duty_full = 1'b0;
        run(60, 1);
        // R9: shorten the line while the count is mid-way
        rate_hi = 1'b0;
        run(7, 1);
        rate_hi = 1'b1;
        run(100, 1);
        tag = "R2,R3";
        run_rand(400);
        // reset again mid-frame (R1)
        @(negedge clk);
        rst = 1'b1;
        run(3, 1);
        rst = 1'b0;
        run(50, 1);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule